// File: doc/BRIEF.md
# Dead-Band Complementary PWM Generator

This block drives one complementary pair of pulse-width-modulated outputs from a 16-bit timer. The timer either counts up and wraps, which gives edge-aligned pulses, or counts up then down, which gives pulses centred on the counter's zero point. A compare value sets the pulse width and a period value sets the carrier frequency. Software writes both values into shadow copies at any time. The active copies pick them up only at a period boundary, so a new width or period never produces a partial pulse.

A programmable dead-band holds both outputs low for a set number of ticks after every change of the raw waveform. This means one side switches on only after the other side has switched off. An external fault input, when enabled, forces both outputs low and raises a sticky interrupt flag. The flag stays set until software clears it.

Software uses a simple write port. Address 0 is the compare shadow and address 1 is the period shadow. Address 2 is the control word. Address 3 holds the dead-band length in bits [7:0]. A write to address 4 with bit 0 set clears the fault flag.

Top module: `pwm_deadband_unit`

## Requirements
- R1: While reset is held and right after it is released, pwmHi, pwmLo and tripIrq are all 0, and the unit is disabled.
- R2: With control bit 0 = 1 (run) and bit 1 = 0 (up mode), the counter steps 0,1,...,P then wraps to 0, so the carrier lasts P+1 ticks. The raw waveform is high while counter < compare: compare 0 gives no high time and compare > P gives constant high.
- R3: With control bit 1 = 1 (up-down mode), the counter steps 0 up to P and back down to 0, so the carrier lasts 2P ticks. The raw waveform is high while counter < compare, which centres the pulse on zero.
- R4: Writes to address 0 or 1 change only the shadow copies. The active compare and period load from the shadows in the tick where the counter equals 0. In up-down mode with control bit 2 = 1, they also load where the counter equals the active period.
- R5: Each change of the raw waveform holds both outputs low for D ticks, where D is the dead-band value (address 3, bits [7:0]). After that, pwmHi follows the raw waveform and pwmLo follows its inverse. D = 0 makes them exact complements, and the two outputs are never high together.
- R6: With control bit 3 = 1 (fault enabled), tripIn high at a clock edge sets tripIrq after that edge, and both outputs go low.
- R7: With control bit 3 = 0, tripIn has no effect on tripIrq or on the outputs.
- R8: tripIrq stays set, with both outputs low, until a write of 1 to address 4 bit 0. If a new fault arrives in the same cycle as the clear, the fault wins.
- R9: With control bit 0 = 0, both outputs are low and the counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock, one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Write address (0 compare, 1 period, 2 control, 3 dead-band, 4 fault clear) |
| wrData | input | 16 | Write data |
| tripIn | input | 1 | External fault input, active high |
| pwmHi | output | 1 | High-side drive output |
| pwmLo | output | 1 | Low-side drive output |
| tripIrq | output | 1 | Sticky fault flag and interrupt |

## Verification
Three pairs of events can coincide in one cycle. A fault clear can arrive while tripIn is still high. A shadow write can land exactly on the tick where the counter is at zero, or at the period point. A raw-waveform edge can occur while a previous dead-band delay is still counting. The bench creates the first by issuing the clear write while holding the fault input. It creates the second by writing compare and period at arbitrary phases during a long run. It creates the third with short pulses against a long dead-band. A behavioural reference model predicts the outputs every clock, and directed window counts of high ticks confirm the pulse widths and dead-band loss.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CMP  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PRD  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DB   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic cntDec;
    logic loadAct;
    logic wrCmp;
    logic wrPrd;
    logic wrDb;
  } dpStrobe_t;
endpackage

// File: rtl/pwm_db_ctrl.sv
module pwm_db_ctrl
  import pwm_db_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrBits,
  input  logic              tripIn,
  input  logic              atZero,
  input  logic              atPrd,
  input  logic              geP,
  output dpStrobe_t         stb,
  output logic              runEn,
  output logic              tripFlag
);
  logic modeUd, loadAtPrd, tripEn, dirUp, dirNext;
  logic setTrip, clrTrip;

  assign setTrip = tripEn && tripIn;
  assign clrTrip = wrEn && (wrAddr == ADR_CLR) && wrBits[0];

  always_comb begin
    stb       = '0;
    dirNext   = dirUp;
    stb.wrCmp = wrEn && (wrAddr == ADR_CMP);
    stb.wrPrd = wrEn && (wrAddr == ADR_PRD);
    stb.wrDb  = wrEn && (wrAddr == ADR_DB);
    stb.loadAct = atZero || (modeUd && loadAtPrd && atPrd);
    if (!runEn) begin
      stb.cntClr = 1'b1;
      dirNext    = 1'b1;
    end else if (!modeUd) begin
      dirNext = 1'b1;
      if (geP) stb.cntClr = 1'b1;
      else     stb.cntInc = 1'b1;
    end else if (dirUp) begin
      if (geP) begin
        dirNext = 1'b0;
        if (!atZero) stb.cntDec = 1'b1;
      end else begin
        stb.cntInc = 1'b1;
      end
    end else begin
      if (atZero) begin
        dirNext = 1'b1;
        if (!geP) stb.cntInc = 1'b1;
      end else begin
        stb.cntDec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      modeUd    <= 1'b0;
      loadAtPrd <= 1'b0;
      tripEn    <= 1'b0;
      dirUp     <= 1'b1;
      tripFlag  <= 1'b0;
    end else begin
      dirUp <= dirNext;
      if (wrEn && (wrAddr == ADR_CTRL)) begin
        runEn     <= wrBits[0];
        modeUd    <= wrBits[1];
        loadAtPrd <= wrBits[2];
        tripEn    <= wrBits[3];
      end
      if (setTrip)      tripFlag <= 1'b1;
      else if (clrTrip) tripFlag <= 1'b0;
    end
  end

  // R6: an enabled fault sets the flag on the next cycle
  a_r6_trip_sets: assert property (@(posedge clk) disable iff (!rstN)
    (tripEn && tripIn) |=> tripFlag);
  // R8: flag holds unless a clear is written
  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (tripFlag && !(wrEn && wrAddr == ADR_CLR && wrBits[0])) |=> tripFlag);
  // R9: a disabled unit parks the counter at zero
  a_r9_park_zero: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> atZero);
  // R2: up mode wraps to zero once the period is reached
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !modeUd && geP) |=> atZero);
endmodule

// File: rtl/pwm_db_datapath.sv
module pwm_db_datapath
  import pwm_db_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             runEn,
  input  logic             tripFlag,
  output logic             atZero,
  output logic             atPrd,
  output logic             geP,
  output logic             pwmHi,
  output logic             pwmLo
);
  logic [CNT_W-1:0] cnt, cmpSh, prdSh, cmpAct, prdAct;
  logic [DB_W-1:0]  dbVal, dbCnt;
  logic             raw, rawQ, dbZero;

  assign atZero = (cnt == '0);
  assign atPrd  = (cnt == prdAct);
  assign geP    = (cnt >= prdAct);
  assign raw    = runEn && (cnt < cmpAct);
  assign dbZero = (dbCnt == '0);
  assign pwmHi  = runEn && !tripFlag && rawQ && dbZero;
  assign pwmLo  = runEn && !tripFlag && !rawQ && dbZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      cmpSh  <= '0;
      prdSh  <= '0;
      cmpAct <= '0;
      prdAct <= '0;
      dbVal  <= '0;
      dbCnt  <= '0;
      rawQ   <= 1'b0;
    end else begin
      if (stb.cntClr)      cnt <= '0;
      else if (stb.cntInc) cnt <= cnt + 1'b1;
      else if (stb.cntDec) cnt <= cnt - 1'b1;
      if (stb.wrCmp) cmpSh <= wrData;
      if (stb.wrPrd) prdSh <= wrData;
      if (stb.wrDb)  dbVal <= wrData[DB_W-1:0];
      if (stb.loadAct) begin
        cmpAct <= cmpSh;
        prdAct <= prdSh;
      end
      rawQ <= raw;
      if (raw != rawQ)  dbCnt <= dbVal;
      else if (!dbZero) dbCnt <= dbCnt - 1'b1;
    end
  end

  // R4: active values move only on a load strobe
  a_r4_hold_active: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadAct |=> ($stable(cmpAct) && $stable(prdAct)));
  // R5: a raw edge with nonzero dead-band blanks both outputs
  a_r5_gap: assert property (@(posedge clk) disable iff (!rstN)
    ((raw != rawQ) && (dbVal != '0)) |=> (!pwmHi && !pwmLo));
  // R5: never both high
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(pwmHi && pwmLo));
endmodule

// File: rtl/pwm_deadband_unit.sv
module pwm_deadband_unit
  import pwm_db_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tripIn,
  output logic              pwmHi,
  output logic              pwmLo,
  output logic              tripIrq
);
  dpStrobe_t stb;
  logic runEn, tripFlag, atZero, atPrd, geP;

  pwm_db_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBits(wrData[3:0]), .tripIn(tripIn),
    .atZero(atZero), .atPrd(atPrd), .geP(geP),
    .stb(stb), .runEn(runEn), .tripFlag(tripFlag)
  );

  pwm_db_datapath #(.CNT_W(CNT_W), .DB_W(DB_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .runEn(runEn), .tripFlag(tripFlag),
    .atZero(atZero), .atPrd(atPrd), .geP(geP),
    .pwmHi(pwmHi), .pwmLo(pwmLo)
  );

  assign tripIrq = tripFlag;

  // R6: a raised flag keeps the drive outputs off
  a_r6_outputs_safe: assert property (@(posedge clk) disable iff (!rstN)
    tripIrq |-> (!pwmHi && !pwmLo));
endmodule

// File: tb/pwm_deadband_unit_tb_top.sv
`timescale 1ns/1ps
module pwm_deadband_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic tripIn = 1'b0;
  logic pwmHi, pwmLo, tripIrq;

  always #2.5 clk = ~clk;

  pwm_deadband_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tripIn(tripIn), .pwmHi(pwmHi), .pwmLo(pwmLo), .tripIrq(tripIrq)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference state
  int mCnt = 0, mDir = 1, mCmpSh = 0, mPrdSh = 0, mCmpAct = 0, mPrdAct = 0;
  int mDb = 0, mRawQ = 0, mDbCnt = 0, mEn = 0, mUd = 0, mLap = 0, mTe = 0, mTrip = 0;

  always @(posedge clk) begin : refModel
    int raw, nCnt, nDir, nDbCnt, ld;
    if (!rstN) begin
      mCnt = 0; mDir = 1; mCmpSh = 0; mPrdSh = 0; mCmpAct = 0; mPrdAct = 0;
      mDb = 0; mRawQ = 0; mDbCnt = 0; mEn = 0; mUd = 0; mLap = 0; mTe = 0; mTrip = 0;
    end else begin
      raw = (mEn != 0 && mCnt < mCmpAct) ? 1 : 0;
      if (raw != mRawQ) nDbCnt = mDb;
      else if (mDbCnt != 0) nDbCnt = mDbCnt - 1;
      else nDbCnt = 0;
      ld = (mCnt == 0 || (mUd != 0 && mLap != 0 && mCnt == mPrdAct)) ? 1 : 0;
      nCnt = mCnt; nDir = mDir;
      if (mEn == 0) begin nCnt = 0; nDir = 1; end
      else if (mUd == 0) begin nDir = 1; nCnt = (mCnt >= mPrdAct) ? 0 : mCnt + 1; end
      else if (mDir != 0) begin
        if (mCnt >= mPrdAct) begin nDir = 0; if (mCnt != 0) nCnt = mCnt - 1; end
        else nCnt = mCnt + 1;
      end else begin
        if (mCnt == 0) begin nDir = 1; if (mPrdAct > 0) nCnt = 1; end
        else nCnt = mCnt - 1;
      end
      if (mTe != 0 && tripIn) mTrip = 1;
      else if (wrEn && wrAddr == 3'd4 && wrData[0]) mTrip = 0;
      if (ld != 0) begin mCmpAct = mCmpSh; mPrdAct = mPrdSh; end
      mRawQ = raw; mDbCnt = nDbCnt; mCnt = nCnt; mDir = nDir;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mCmpSh = int'(wrData);
          3'd1: mPrdSh = int'(wrData);
          3'd2: begin mEn = int'(wrData[0]); mUd = int'(wrData[1]);
                      mLap = int'(wrData[2]); mTe = int'(wrData[3]); end
          3'd3: mDb = int'(wrData[7:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      int eHi, eLo;
      eHi = (mEn != 0 && mTrip == 0 && mRawQ != 0 && mDbCnt == 0) ? 1 : 0;
      eLo = (mEn != 0 && mTrip == 0 && mRawQ == 0 && mDbCnt == 0) ? 1 : 0;
      check(curReq, "pwmHi", int'(pwmHi), eHi);
      check(curReq, "pwmLo", int'(pwmLo), eLo);
      check(curReq, "tripIrq", int'(tripIrq), mTrip);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic countHigh(input int n, output int hi, output int lo);
    hi = 0; lo = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.5;
      hi += int'(pwmHi);
      lo += int'(pwmLo);
    end
  endtask

  task automatic finishRun;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    int h, l;
    idle(4);
    check("R1", "hi in reset", int'(pwmHi), 0);
    check("R1", "irq in reset", int'(tripIrq), 0);
    rstN = 1'b1;
    idle(2);
    check("R1", "lo after reset", int'(pwmLo), 0);

    curReq = "R9";
    wr(0, 4); wr(1, 9);
    countHigh(10, h, l);
    check("R9", "disabled hi+lo", h + l, 0);

    curReq = "R2";
    wr(2, 1);
    idle(25);
    countHigh(50, h, l);
    check("R2", "up hi ticks", h, 20);
    check("R2", "up lo ticks", l, 30);

    curReq = "R5";
    wr(3, 3);
    idle(20);
    countHigh(50, h, l);
    check("R5", "db3 hi ticks", h, 5);
    check("R5", "db3 lo ticks", l, 15);
    wr(3, 8);
    idle(40);
    wr(3, 0);
    idle(20);
    countHigh(30, h, l);
    check("R5", "db0 complement", h + l, 30);

    curReq = "R4";
    for (int k = 0; k < 6; k++) begin
      wr(0, 2 + k); idle(3 + k); wr(1, 6 + 2 * k); idle(7);
    end
    wr(0, 0); wr(1, 9); idle(25);
    countHigh(20, h, l);
    check("R2", "cmp 0 hi", h, 0);
    wr(0, 12); idle(25);
    countHigh(20, h, l);
    check("R2", "cmp above period hi", h, 20);
    wr(1, 0); idle(20);

    curReq = "R3";
    wr(0, 3); wr(1, 6); wr(2, 3);
    idle(30);
    countHigh(60, h, l);
    check("R3", "updown hi ticks", h, 25);
    wr(2, 7);
    for (int k = 0; k < 8; k++) begin
      wr(0, 1 + k); idle(2 + k); wr(1, 4 + k); idle(5);
    end
    wr(3, 2);
    wr(0, 1); wr(1, 3);
    idle(40);

    curReq = "R7";
    wr(3, 0); wr(0, 4); wr(1, 9); wr(2, 1);
    idle(20);
    @(negedge clk); tripIn = 1'b1;
    idle(3);
    tripIn = 1'b0;
    idle(1);
    check("R7", "masked trip irq", int'(tripIrq), 0);
    countHigh(20, h, l);
    check("R7", "masked trip outputs", h + l, 20);

    curReq = "R6";
    wr(2, 9);
    idle(5);
    @(negedge clk); tripIn = 1'b1;
    @(negedge clk); tripIn = 1'b0;
    check("R6", "trip irq", int'(tripIrq), 1);
    countHigh(20, h, l);
    check("R6", "tripped outputs", h + l, 0);

    curReq = "R8";
    @(negedge clk); tripIn = 1'b1;
    wr(4, 1);
    check("R8", "set beats clear", int'(tripIrq), 1);
    tripIn = 1'b0;
    idle(5);
    check("R8", "held flag", int'(tripIrq), 1);
    wr(4, 1);
    check("R8", "cleared flag", int'(tripIrq), 0);
    idle(20);
    countHigh(20, h, l);
    check("R8", "resumed outputs", h + l, 20);

    curReq = "R9";
    wr(2, 0);
    countHigh(10, h, l);
    check("R9", "disabled again", h + l, 0);
    finishRun();
  end
endmodule